// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block sits beside a phase-locked loop and decides from purely digital evidence whether the loop has settled. It receives two single-cycle strobes from the phase-frequency detector, one for each reference edge and one for each feedback edge. Both strobes are already synchronous to the sample clock. For every comparison cycle it measures in sample-clock ticks how far apart the two edges landed. It then grades the comparison as good when that distance is inside a programmable window.

While unlocked, the block needs a long unbroken run of good comparisons, 2^LOCK_LOG2 of them (65536 by default), before it raises the lock flag. A single bad comparison throws the run away, so after a large phase disturbance reacquisition can take many times the nominal count. While locked, bad comparisons are tallied and the flag drops once the tally reaches a programmable limit. Good comparisons do not clear the tally. The limit is capped at 2^UNL_W (32768 by default), which bounds how long a real loss of lock can go unreported. One-cycle event pulses mark each transition.

Top module: `pll_lock_detect`

## Requirements
- R1: While rst_n is low, locked, lock_evt and unlock_evt are 0, and after release both internal tallies start from zero.
- R2: A comparison starts at the first ref_stb or fb_stb seen while idle and closes at the first strobe of the other kind. Its error is the number of sample-clock cycles between the two strobes, and strobes in the same cycle give error 0. The comparison is good exactly when the error is less than or equal to win_thresh.
- R3: While unlocked, locked rises in the cycle after the closing strobe of the 2^LOCK_LOG2-th consecutive good comparison, and not before.
- R4: While unlocked, any bad comparison restarts the count of consecutive good comparisons from zero.
- R5: lock_evt and unlock_evt are each exactly one cycle wide and are asserted in the same cycle that locked rises or falls.
- R6: While locked, every bad comparison adds one to a tally that good comparisons leave unchanged. locked falls in the cycle after the bad comparison that brings the tally to the effective limit, and the tally then clears.
- R7: The effective unlock limit is unlock_limit, except that a value of 0 acts as 1 and any value above 2^UNL_W acts as 2^UNL_W.
- R8: If the closing strobe has not arrived by the cycle in which 2^ERR_W-1 ticks have elapsed since the leading strobe, the comparison ends as bad in that cycle.
- R9: A second strobe of the leading kind before the closing strobe ends the open comparison as bad and starts a new comparison led by that second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe per reference edge |
| fb_stb | input | 1 | One-cycle strobe per feedback edge |
| win_thresh | input | ERR_W | Largest error in ticks that still counts as good |
| unlock_limit | input | UNL_W+1 | Bad comparisons while locked that cause unlock |
| locked | output | 1 | Lock flag |
| lock_evt | output | 1 | One-cycle pulse when lock is declared |
| unlock_evt | output | 1 | One-cycle pulse when lock is lost |

## Verification
Every comparison is graded in the cycle of its closing strobe, or in the timeout cycle. The lock flag and both event pulses are registered one clock edge after that cycle. The bench drives each comparison inside a fixed 24-cycle frame, with every strobe at or before cycle 15. It compares the flag against its own model only at the end of the frame, when the result has been stable for at least seven cycles. Event pulses are counted on every falling clock edge and compared with the expected totals at the same frame-end point, so a late, missing or doubled pulse shows up as a count mismatch.

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int LOCK_LOG2 = 16,
  parameter int ERR_W     = 8,
  parameter int UNL_W     = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb,
  input  logic             fb_stb,
  input  logic [ERR_W-1:0] win_thresh,
  input  logic [UNL_W:0]   unlock_limit,
  output logic             locked,
  output logic             lock_evt,
  output logic             unlock_evt
);

  localparam logic [ERR_W-1:0]     CNT_MAX   = '1;
  localparam logic [LOCK_LOG2-1:0] GOOD_LAST = '1;
  localparam logic [UNL_W:0]       UNL_MAX   = {1'b1, {UNL_W{1'b0}}};

  logic                 busy, lead_ref;
  logic [ERR_W-1:0]     cnt;
  logic [LOCK_LOG2-1:0] good_cnt;
  logic [UNL_W:0]       bad_cnt;
  logic [UNL_W:0]       eff_limit;
  logic [UNL_W+1:0]     bad_next;

  wire lead_hit  = busy & (lead_ref ? ref_stb : fb_stb);
  wire close     = busy & (lead_ref ? fb_stb : ref_stb);
  wire repeat_ld = lead_hit & ~close;
  wire timeout   = busy & ~close & ~repeat_ld & (cnt == CNT_MAX);
  wire same_cyc  = ~busy & ref_stb & fb_stb;
  wire cmp_valid = same_cyc | close | repeat_ld | timeout;
  wire cmp_good  = same_cyc | (close & (cnt <= win_thresh));

  assign eff_limit = (unlock_limit == '0)    ? {{UNL_W{1'b0}}, 1'b1} :
                     (unlock_limit > UNL_MAX) ? UNL_MAX : unlock_limit;
  assign bad_next  = {1'b0, bad_cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      lead_ref <= 1'b0;
      cnt      <= '0;
    end else if (!busy) begin
      if (ref_stb ^ fb_stb) begin
        busy     <= 1'b1;
        lead_ref <= ref_stb;
        cnt      <= {{(ERR_W-1){1'b0}}, 1'b1};
      end
    end else if (close || timeout) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (repeat_ld) begin
      cnt <= {{(ERR_W-1){1'b0}}, 1'b1};
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      lock_evt   <= 1'b0;
      unlock_evt <= 1'b0;
      good_cnt   <= '0;
      bad_cnt    <= '0;
    end else begin
      lock_evt   <= 1'b0;
      unlock_evt <= 1'b0;
      if (cmp_valid) begin
        if (!locked) begin
          if (!cmp_good) begin
            good_cnt <= '0;
          end else if (good_cnt == GOOD_LAST) begin
            locked   <= 1'b1;
            lock_evt <= 1'b1;
            good_cnt <= '0;
          end else begin
            good_cnt <= good_cnt + 1'b1;
          end
        end else if (!cmp_good) begin
          if (bad_next >= {1'b0, eff_limit}) begin
            locked     <= 1'b0;
            unlock_evt <= 1'b1;
            bad_cnt    <= '0;
          end else begin
            bad_cnt <= bad_next[UNL_W:0];
          end
        end
      end
    end
  end

  a_r5_lock_evt_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> !lock_evt);
  a_r5_unlock_evt_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_evt |=> !unlock_evt);
  a_r5_rise_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> lock_evt && !unlock_evt);
  a_r6_fall_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> unlock_evt && !lock_evt);
  a_r3_run_idle_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> good_cnt == '0);
  a_r6_tally_idle_when_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> bad_cnt == '0);
  a_r8_timeout_ends_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !busy);

endmodule

// File: tb/pll_lock_detect_tb.sv
`timescale 1ns/1ps
module pll_lock_detect_tb;
  localparam int LOCK_LOG2 = 5;
  localparam int ERR_W     = 4;
  localparam int UNL_W     = 4;
  localparam int LOCK_N    = 1 << LOCK_LOG2;
  localparam int P         = 24;

  logic clk = 0, rst_n = 0, ref_stb = 0, fb_stb = 0;
  logic [ERR_W-1:0] win_thresh = 3;
  logic [UNL_W:0]   unlock_limit = 3;
  logic locked, lock_evt, unlock_evt;

  pll_lock_detect #(.LOCK_LOG2(LOCK_LOG2), .ERR_W(ERR_W), .UNL_W(UNL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .win_thresh(win_thresh), .unlock_limit(unlock_limit),
    .locked(locked), .lock_evt(lock_evt), .unlock_evt(unlock_evt));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int seen_lk = 0, seen_ul = 0, exp_lk = 0, exp_ul = 0;
  int gc = 0, bc = 0;
  bit el = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (lock_evt) seen_lk++;
    if (unlock_evt) seen_ul++;
  end

  function automatic int eff_lim(int l);
    if (l == 0) return 1;
    if (l > (1 << UNL_W)) return 1 << UNL_W;
    return l;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_cmp(bit good);
    if (!el) begin
      if (good) begin
        if (gc == LOCK_N - 1) begin el = 1; exp_lk++; gc = 0; end
        else gc++;
      end else gc = 0;
    end else if (!good) begin
      if (bc + 1 >= eff_lim(int'(unlock_limit))) begin el = 0; exp_ul++; bc = 0; end
      else bc++;
    end
  endtask

  task automatic drive(int r0, int r1, int f0);
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      ref_stb = (i == r0) || (i == r1);
      fb_stb  = (i == f0);
    end
    @(negedge clk);
    ref_stb = 0; fb_stb = 0;
  endtask

  task automatic check_state(string req);
    chk(locked == el, req, int'(locked), int'(el));
    chk(seen_lk == exp_lk && seen_ul == exp_ul, {req, " events"},
        seen_lk * 1000 + seen_ul, exp_lk * 1000 + exp_ul);
  endtask

  task automatic pair(int d, string req);
    drive(8, -1, 8 + d);
    model_cmp((d < 0 ? -d : d) <= int'(win_thresh));
    check_state(req);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(locked == 0 && lock_evt == 0 && unlock_evt == 0, "R1 in reset", int'(locked), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_state("R1 after release");

    for (int k = 0; k < LOCK_N - 1; k++) pair((k % 7) - 3, "R3 qualifying");
    pair(5, "R4 bad restarts");
    for (int k = 0; k < LOCK_N - 1; k++) pair(0, "R4 requalify");
    chk(locked == 0, "R3 not before full run", int'(locked), 0);
    pair(-3, "R3 lock on last good");
    chk(locked == 1, "R3 locked", int'(locked), 1);

    unlock_limit = 3;
    pair(6, "R6 first bad");
    pair(1, "R6 good keeps tally");
    pair(-6, "R6 second bad");
    chk(locked == 1, "R6 still locked", int'(locked), 1);
    pair(4, "R6 limit reached");
    chk(locked == 0, "R6 unlocked", int'(locked), 0);

    win_thresh = 2;
    drive(0, 3, 5); model_cmp(0); model_cmp(1);
    check_state("R9 repeated lead");
    pair(2, "R2 edge of window");
    pair(3, "R2 just outside");
    pair(0, "R2 same cycle");

    for (int k = 0; k < LOCK_N; k++) pair(-2, "R3 relock");
    unlock_limit = 0;
    drive(0, -1, -1); model_cmp(0);
    check_state("R8 timeout, R7 zero limit");
    chk(locked == 0, "R7 zero acts as one", int'(locked), 0);

    for (int k = 0; k < LOCK_N; k++) pair(1, "R3 relock");
    unlock_limit = 31;
    for (int k = 0; k < (1 << UNL_W); k++) pair(7, "R7 clamp");
    chk(locked == 0, "R7 clamped limit", int'(locked), 0);

    for (int k = 0; k < LOCK_N; k++) pair(0, "R3 relock");
    @(negedge clk); rst_n = 0; #1;
    chk(locked == 0, "R1 async reset", int'(locked), 0);
    el = 0; gc = 0; bc = 0;
    @(negedge clk); rst_n = 1;

    for (int k = 0; k < 500; k++) begin
      int d;
      if (k % 50 == 0) begin
        win_thresh = ERR_W'($urandom_range(1, 5));
        unlock_limit = (UNL_W+1)'($urandom_range(0, 20));
      end
      if ($urandom_range(0, 19) < 19) d = $urandom_range(0, 6) - 3;
      else d = $urandom_range(0, 14) - 7;
      pair(d, "R2 R3 R4 R6 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #(200000 * 4);
    join_any
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule